// File: doc/BRIEF.md
# Buffered Three-Output PWM Timer

A 16-bit up-counting timer that produces three pulse-width-modulated outputs from one shared period register and three change-point registers. While the start input is high the counter runs from zero up to the period value and then clears, so every period is one cycle longer than the period value. Each output is inactive at the start of a period and becomes active once the counter passes that output's change point. A per-output polarity bit inverts the pin.

Two mode bits turn the third and fourth compare registers into staging registers. In that mode they no longer drive their own pins. Instead they hold the next period and the next change point of the first output, and those values are copied in at the period boundary. Software can therefore rewrite the period or the duty at any time without producing a short or torn cycle. A one-cycle event pulse marks each period match for a downstream transfer or event-link unit. When the period value is zero, the pulse is issued only once after counting starts.

All registers sit behind a simple write port with a combinational read port.

Top module: `pwm_buf_timer`

## Requirements
- R1: After reset the period and the three change-point registers read FFFFh, the mode register reads 0, all pins are low and the event output is low.
- R2: Register addresses are 0 = period, 1 = change point B, 2 = change point C, 3 = change point D and 4 = mode, and a value written to any of them reads back unchanged. Address 5 returns the counter and ignores writes. Mode bits are: bit 0 = C buffers the period, bit 1 = D buffers change point B, bits 2/3/4 = polarity of pins 0/1/2 (outputs B/C/D). The read data follows the address in the same cycle.
- R3: While start is high, the counter steps from 0 to the period value and clears on the next cycle. Each period therefore lasts period+1 cycles, and the first period begins on the first clock edge with start high.
- R4: Before polarity is applied, each output is low while the counter is at or below its change point and high while the counter is above it. Each period therefore has period - change point active cycles, and none when the change point is at or above the period.
- R5: A polarity bit of 1 inverts its pin, so the pin's inactive level is high.
- R6: With mode bit 0 set, pin 1 stays at its inactive level, and register C is copied into the period register only at a period boundary. The period in progress keeps its old length.
- R7: With mode bit 1 set, pin 2 stays at its inactive level, and register D is copied into change point B at a period boundary.
- R8: While start is low the counter holds at 0, every pin stays at its inactive level and no event is issued.
- R9: With a nonzero period, the event output is high for exactly one cycle after every period match. That cycle is the first cycle of the next period.
- R10: With a period value of 0, exactly one event pulse is issued after start rises, and none follow while start stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Count enable; low holds the counter at zero |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the addressed register |
| pwm | output | 3 | PWM pins: bit 0 from B, bit 1 from C, bit 2 from D |
| evt | output | 1 | One-cycle event request on period match |

## Verification
The pulse generation is exercised in several ways. Directed cases cover a change point of zero, a change point equal to the period, and a change point beyond it. These separate the full-duty, zero-duty and off-range behaviour of the compare. Randomised periods, change points, polarities and buffer modes then check the period length and each pin's active-cycle count against computed values. Buffered runs measure the first period and the next one separately and read the period register before and after the boundary, which shows whether the copy happens too early or not at all. Event counts over fixed windows with periods of 0 and 1 distinguish the once-only rule from the every-match rule.

// File: rtl/pwm_buf_pkg.sv
package pwm_buf_pkg;

    localparam int unsigned NUM_CH = 3;
    localparam int unsigned MODE_W = 5;

    typedef enum logic [2:0] {
        ADDR_PER  = 3'd0,
        ADDR_CMPB = 3'd1,
        ADDR_CMPC = 3'd2,
        ADDR_CMPD = 3'd3,
        ADDR_MODE = 3'd4,
        ADDR_CNT  = 3'd5
    } reg_addr_e;

    // bit 0 = buf_c ... bit 4 = pol_d
    typedef struct packed {
        logic pol_d;
        logic pol_c;
        logic pol_b;
        logic buf_d;
        logic buf_c;
    } mode_t;

endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
    import pwm_buf_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [2:0]   addr,
    input  logic [W-1:0] wdata,
    input  logic         wrap,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] per,
    output logic [W-1:0] cmp_b,
    output logic [W-1:0] cmp_c,
    output logic [W-1:0] cmp_d,
    output mode_t        mode,
    output logic [W-1:0] rdata
);

    localparam int unsigned PAD_W = W - MODE_W;

    typedef struct packed {
        logic [W-1:0] per;
        logic [W-1:0] cb;
        logic [W-1:0] cc;
        logic [W-1:0] cd;
        mode_t        mode;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        // boundary copies from the staging registers
        if (wrap) begin
            if (r_q.mode.buf_c) r_d.per = r_q.cc;
            if (r_q.mode.buf_d) r_d.cb  = r_q.cd;
        end
        // a software write in the same cycle takes priority
        if (wr_en) begin
            case (addr)
                ADDR_PER:  r_d.per  = wdata;
                ADDR_CMPB: r_d.cb   = wdata;
                ADDR_CMPC: r_d.cc   = wdata;
                ADDR_CMPD: r_d.cd   = wdata;
                ADDR_MODE: r_d.mode = mode_t'(wdata[MODE_W-1:0]);
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.per  <= '1;
            r_q.cb   <= '1;
            r_q.cc   <= '1;
            r_q.cd   <= '1;
            r_q.mode <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (addr)
            ADDR_PER:  rdata = r_q.per;
            ADDR_CMPB: rdata = r_q.cb;
            ADDR_CMPC: rdata = r_q.cc;
            ADDR_CMPD: rdata = r_q.cd;
            ADDR_MODE: rdata = {{PAD_W{1'b0}}, r_q.mode};
            ADDR_CNT:  rdata = cnt;
            default:   rdata = '0;
        endcase
    end

    assign per   = r_q.per;
    assign cmp_b = r_q.cb;
    assign cmp_c = r_q.cc;
    assign cmp_d = r_q.cd;
    assign mode  = r_q.mode;

    // R6
    buf_period_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && r_q.mode.buf_c && !(wr_en && addr == ADDR_PER)) |=> (r_q.per == $past(r_q.cc)));

    // R7
    buf_cmpb_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && r_q.mode.buf_d && !(wr_en && addr == ADDR_CMPB)) |=> (r_q.cb == $past(r_q.cd)));

    // R2
    write_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_CMPC) |=> (r_q.cc == $past(wdata)));

    // R6
    period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap && !(wr_en && addr == ADDR_PER)) |=> $stable(r_q.per));

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] per,
    output logic [W-1:0] cnt,
    output logic         wrap,
    output logic         evt
);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         armed;
        logic         evt;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    assign wrap = run && (s_q.cnt == per);

    always_comb begin
        s_d = s_q;
        if (!run) begin
            s_d.cnt   = '0;
            s_d.armed = 1'b1;
            s_d.evt   = 1'b0;
        end else begin
            s_d.armed = 1'b0;
            // a zero period only signals on the first counted cycle
            s_d.evt   = wrap && ((per != '0) || s_q.armed);
            s_d.cnt   = wrap ? '0 : s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt   <= '0;
            s_q.armed <= 1'b1;
            s_q.evt   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt = s_q.cnt;
    assign evt = s_q.evt;

    // R8
    idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (s_q.cnt == '0));

    // R3
    wrap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (s_q.cnt == '0));

    // R9
    evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.evt |=> !s_q.evt);

    // R8
    evt_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.evt |-> $past(run));

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         enable,
    input  logic         pol,
    input  logic         wrap,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp,
    output logic         pin
);

    typedef struct packed {
        logic raw;
    } ch_state_t;

    ch_state_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (!run || !enable) begin
            c_d.raw = 1'b0;
        end else if (wrap) begin
            c_d.raw = 1'b0;          // period start wins over a match
        end else if (cnt == cmp) begin
            c_d.raw = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.raw <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign pin = c_q.raw ^ pol;

    // R8
    chan_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !c_q.raw);

    // R4
    chan_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_q.raw) |-> $past(cnt == cmp));

    // R4
    chan_period_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> !c_q.raw);

endmodule

// File: rtl/pwm_buf_timer.sv
module pwm_buf_timer
    import pwm_buf_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      rdata,
    output logic [NUM_CH-1:0] pwm,
    output logic              evt
);

    logic [W-1:0] per, cmp_b, cmp_c, cmp_d, cnt;
    logic         wrap;
    mode_t        mode;

    logic [W-1:0]      cmp_arr [NUM_CH];
    logic [NUM_CH-1:0] en_arr;
    logic [NUM_CH-1:0] pol_arr;

    pwm_regfile #(.W(W)) i_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .wrap  (wrap),
        .cnt   (cnt),
        .per   (per),
        .cmp_b (cmp_b),
        .cmp_c (cmp_c),
        .cmp_d (cmp_d),
        .mode  (mode),
        .rdata (rdata)
    );

    pwm_counter #(.W(W)) i_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .per   (per),
        .cnt   (cnt),
        .wrap  (wrap),
        .evt   (evt)
    );

    assign cmp_arr[0] = cmp_b;
    assign cmp_arr[1] = cmp_c;
    assign cmp_arr[2] = cmp_d;
    assign en_arr     = {~mode.buf_d, ~mode.buf_c, 1'b1};
    assign pol_arr    = {mode.pol_d, mode.pol_c, mode.pol_b};

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_channel #(.W(W)) i_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (run),
            .enable (en_arr[g]),
            .pol    (pol_arr[g]),
            .wrap   (wrap),
            .cnt    (cnt),
            .cmp    (cmp_arr[g]),
            .pin    (pwm[g])
        );
    end

    // R1
    reset_pins_chk: assert property (@(posedge clk)
        !rst_n |-> (pwm == pol_arr) && !evt);

endmodule

// File: tb/test_pwm_buf_timer.sv
module test_pwm_buf_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic [2:0]  pwm;
    logic        evt;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    pwm_buf_timer #(.W(16)) i_pwm_buf_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .pwm   (pwm),
        .evt   (evt)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    function automatic int exp_hi(input int per, input int cmp);
        return (cmp < per) ? per - cmp : 0;
    endfunction

    // program, start, measure first period and one full following period
    task automatic run_case(input int per, input int b, input int c, input int d,
                            input logic [4:0] mode, input string tag);
        int first, len, ep, eb;
        int hi[3];
        int ehi[3];
        logic [15:0] a_early, a_late;
        run = 1'b0;
        wr(3'd0, 16'(per)); wr(3'd1, 16'(b)); wr(3'd2, 16'(c)); wr(3'd3, 16'(d));
        wr(3'd4, {11'd0, mode});
        @(negedge clk);
        addr = 3'd0;
        run = 1'b1;
        first = 0; a_early = '0; a_late = '0;
        for (int i = 1; i <= 1000; i++) begin
            @(negedge clk);
            if (i == 1) a_early = rdata;
            if (evt) begin first = i; a_late = rdata; break; end
        end
        len = 0;
        for (int k = 0; k < 3; k++) hi[k] = 0;
        for (int i = 0; i < 2000; i++) begin
            len++;
            for (int k = 0; k < 3; k++) hi[k] += int'(pwm[k]);
            @(negedge clk);
            if (evt) break;
        end
        ep = mode[0] ? c : per;
        eb = mode[1] ? d : b;
        ehi[0] = exp_hi(ep, eb);
        ehi[1] = mode[0] ? 0 : exp_hi(ep, c);
        ehi[2] = mode[1] ? 0 : exp_hi(ep, d);
        for (int k = 0; k < 3; k++)
            if (mode[2+k]) ehi[k] = ep + 1 - ehi[k];
        check("R3", {tag, " first period"}, first, per + 1);
        check("R3", {tag, " period length"}, len, ep + 1);
        check(mode[2] ? "R5" : (mode[1] ? "R7" : "R4"), {tag, " pin0 active"}, hi[0], ehi[0]);
        check(mode[3] ? "R5" : (mode[0] ? "R6" : "R4"), {tag, " pin1 active"}, hi[1], ehi[1]);
        check(mode[4] ? "R5" : (mode[1] ? "R7" : "R4"), {tag, " pin2 active"}, hi[2], ehi[2]);
        if (mode[0]) begin
            check("R6", {tag, " period before boundary"}, int'(a_early), per);
            check("R6", {tag, " period after boundary"}, int'(a_late), c);
        end
        run = 1'b0;
        @(negedge clk);
    endtask

    task automatic count_evt(input int per, input int win, output int n);
        run = 1'b0;
        wr(3'd4, 16'd0);
        wr(3'd0, 16'(per));
        @(negedge clk);
        run = 1'b1;
        n = 0;
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            n += int'(evt);
        end
        run = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #400000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int n;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1", "pins", int'(pwm), 0);
        check("R1", "evt", int'(evt), 0);
        for (int a = 0; a < 4; a++) begin
            rd(3'(a), v);
            check("R1", $sformatf("reg %0d", a), int'(v), 16'hFFFF);
        end
        rd(3'd4, v);
        check("R1", "mode", int'(v), 0);

        // R2 read and write
        wr(3'd0, 16'h1234); wr(3'd1, 16'hA5A5); wr(3'd2, 16'h0F0F); wr(3'd3, 16'h8001);
        wr(3'd4, 16'h001F);
        rd(3'd0, v); check("R2", "period", int'(v), 16'h1234);
        rd(3'd1, v); check("R2", "cmp B", int'(v), 16'hA5A5);
        rd(3'd2, v); check("R2", "cmp C", int'(v), 16'h0F0F);
        rd(3'd3, v); check("R2", "cmp D", int'(v), 16'h8001);
        rd(3'd4, v); check("R2", "mode", int'(v), 16'h001F);
        wr(3'd5, 16'h0077);
        rd(3'd5, v); check("R2", "count ignores write", int'(v), 0);

        // R8 idle with inverted polarity: pins at inactive level, no event
        wr(3'd4, 16'h001C);
        wr(3'd0, 16'd3);
        n = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            n += int'(evt);
            if (pwm != 3'b111) n += 100;
        end
        check("R8", "idle events and pins", n, 0);
        rd(3'd5, v); check("R8", "idle count", int'(v), 0);

        // directed duty corners
        run_case(10, 0, 10, 14, 5'b00000, "zero-cmp/equal/beyond");
        run_case(7, 3, 6, 1, 5'b11100, "inverted");
        run_case(12, 4, 20, 6, 5'b00001, "buffered period");
        run_case(12, 4, 9, 9, 5'b00010, "buffered duty");
        run_case(8, 2, 5, 3, 5'b00011, "both buffered");

        // randomised cases
        for (int it = 0; it < 16; it++) begin
            int p, b, c, d;
            logic [4:0] m;
            p = int'($urandom_range(2, 30));
            m = 5'($urandom_range(0, 31));
            b = int'($urandom_range(0, p + 2));
            c = m[0] ? int'($urandom_range(2, 30)) : int'($urandom_range(0, p + 2));
            d = int'($urandom_range(0, 32));
            run_case(p, b, c, d, m, $sformatf("rand%0d", it));
        end

        // R10 zero period: one pulse only
        count_evt(0, 40, n);
        check("R10", "events with zero period", n, 1);

        // R9 period of one: pulse every other cycle
        count_evt(1, 20, n);
        check("R9", "events with period one", n, 10);

        // R9 period of four over 25 cycles: pulses after edges 5,10,15,20,25
        count_evt(4, 25, n);
        check("R9", "events with period four", n, 5);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule